// File: doc/BRIEF.md
# Dual-Channel Update Handshake Coordinator

This block sits on the controller side of a memory PHY interface that has two channels working together in combined mode. It runs two kinds of update handshake. In a PHY-initiated update, each channel raises its own request whenever it needs one. In a controller-initiated update, the controller asks both channels at the same time. The block turns these handshakes into one shared idle window and asserts a hold signal across it, which keeps both command channels quiet.

When an update is wanted, the coordinator first raises hold. It then waits until the command scheduler reports that both channels have drained. Only then does it grant the update. A PHY update is acknowledged only on the channels whose request is present at the grant. The controller request is always driven identically on both channels. A programmable cycle limit abandons a controller update that nobody acknowledges and raises an error flag.

Top module: `upd_coord`

## Requirements
- R1: The controller update request is driven with the same value on every channel. It rises only after hold is already high and the scheduler reported idle on the previous cycle.
- R2: Hold rises on the clock edge that samples an update need while the block is quiet. Hold is high on every cycle in which any PHY acknowledge or controller request is high.
- R3: A PHY acknowledge is granted on the first edge that sees the scheduler idle input high while hold is up. At that edge, bit i of the acknowledge is set exactly when bit i of the PHY request is high.
- R4: While any PHY acknowledge is high, no acknowledge bit that is low may rise, even if its channel raises a request.
- R5: A PHY acknowledge bit falls on the edge after its channel's request is seen low. Hold falls on the same edge as the last acknowledge bit.
- R6: A controller update counts as acknowledged when any channel's acknowledge is seen high. On that edge the request falls on all channels. Hold then stays high until every channel's acknowledge is seen low, even if the acknowledges fall on different cycles.
- R7: If a controller update need and a PHY request are both sampled in the same quiet cycle, the controller update is served first. A PHY acknowledge and a controller request are never high together.
- R8: If no acknowledge arrives within `upd_limit` edges after the controller request rose, the update is abandoned on the `upd_limit`-th edge. On that edge the request and hold fall and `ctl_err` rises. `ctl_err` clears on the edge that starts the next controller update.
- R9: While `rst` (synchronous, active high) is sampled high, every acknowledge, controller request, hold and `ctl_err` output is low.
- R10: If every PHY request is withdrawn before the grant, hold falls on the next edge and no acknowledge is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_want | input | 1 | Scheduler asks for a controller update (sampled only while quiet) |
| sched_idle | input | 1 | Scheduler reports both command channels drained |
| upd_limit | input | CNT_W | Edges allowed for a controller acknowledge before abort |
| phy_upd_req | input | N_CH | Per-channel PHY update request |
| phy_upd_ack | output | N_CH | Per-channel PHY update acknowledge |
| ctl_upd_req | output | N_CH | Controller update request, identical on all channels |
| ctl_upd_ack | input | N_CH | Per-channel acknowledge of the controller update |
| hold | output | 1 | Keep all command channels idle |
| ctl_err | output | 1 | Last controller update timed out |

## Verification
The checker relies on three assumptions about the PHY. First, a PHY acknowledges a controller update only while the request is up or while its own update is still running. Second, a PHY never raises a controller acknowledge while a PHY update is being served. Third, the scheduler keeps `ctl_want` low once a window has opened. The directed scenarios respect all three. They raise the controller acknowledges only after the request is seen, and they drop `ctl_want` after one sampled cycle. They change PHY requests only between edges. `upd_limit` is never set to zero.

// File: rtl/upd_pkg.sv
package upd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PHY_DRAIN,
        ST_PHY_ACT,
        ST_CTL_DRAIN,
        ST_CTL_WAIT,
        ST_CTL_ACT
    } coord_state_e;

    typedef enum logic [1:0] {
        PICK_NONE,
        PICK_PHY,
        PICK_CTL
    } pick_e;

    // Controller work wins over PHY work when both are seen together.
    function automatic pick_e choose_work(input logic ctl_need, input logic phy_need);
        if (ctl_need)
            return PICK_CTL;
        else if (phy_need)
            return PICK_PHY;
        return PICK_NONE;
    endfunction

    function automatic logic window_open(input coord_state_e st);
        return st != ST_IDLE;
    endfunction

endpackage

// File: rtl/upd_arbiter.sv
module upd_arbiter
    import upd_pkg::*;
#(
    parameter int N_CH = 2
) (
    input  logic            ctl_want,
    input  logic [N_CH-1:0] phy_req,
    output pick_e           pick
);
    logic phy_any;

    always_comb begin
        phy_any = |phy_req;
        pick    = choose_work(ctl_want, phy_any);
    end
endmodule

// File: rtl/upd_ack_lane.sv
module upd_ack_lane (
    input  logic clk,
    input  logic rst,
    input  logic grant,
    input  logic req,
    output logic ack
);
    always_ff @(posedge clk) begin
        if (rst)
            ack <= 1'b0;
        else if (grant)
            ack <= req;
        else
            ack <= ack & req;
    end
endmodule

// File: rtl/upd_ctl_timer.sv
module upd_ctl_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] next_count;

    always_comb begin
        next_count = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
        expire     = next_count >= {1'b0, limit};
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (run)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/upd_coord.sv
module upd_coord
    import upd_pkg::*;
#(
    parameter int N_CH  = 2,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_want,
    input  logic             sched_idle,
    input  logic [CNT_W-1:0] upd_limit,
    input  logic [N_CH-1:0]  phy_upd_req,
    output logic [N_CH-1:0]  phy_upd_ack,
    output logic [N_CH-1:0]  ctl_upd_req,
    input  logic [N_CH-1:0]  ctl_upd_ack,
    output logic             hold,
    output logic             ctl_err
);
    coord_state_e state_q, state_n;
    pick_e        pick;
    logic         grant_phy;
    logic         ctl_req_q, ctl_req_n;
    logic         err_q, err_n;
    logic         hold_q;
    logic         tmr_clear, tmr_run, tmr_expire;
    logic [N_CH-1:0] ack_q;
    logic [N_CH-1:0] ack_keep;

    upd_arbiter #(.N_CH(N_CH)) u_arb (
        .ctl_want (ctl_want),
        .phy_req  (phy_upd_req),
        .pick     (pick)
    );

    upd_ctl_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .clear  (tmr_clear),
        .run    (tmr_run),
        .limit  (upd_limit),
        .expire (tmr_expire)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_lane
        upd_ack_lane u_lane (
            .clk   (clk),
            .rst   (rst),
            .grant (grant_phy),
            .req   (phy_upd_req[ch]),
            .ack   (ack_q[ch])
        );
        assign ctl_upd_req[ch] = ctl_req_q;
    end

    always_comb begin
        state_n   = state_q;
        grant_phy = 1'b0;
        ctl_req_n = ctl_req_q;
        err_n     = err_q;
        tmr_clear = 1'b0;
        tmr_run   = 1'b0;
        ack_keep  = ack_q & phy_upd_req;
        case (state_q)
            ST_IDLE: begin
                if (pick == PICK_CTL) begin
                    state_n = ST_CTL_DRAIN;
                    err_n   = 1'b0;
                end else if (pick == PICK_PHY) begin
                    state_n = ST_PHY_DRAIN;
                end
            end
            ST_PHY_DRAIN: begin
                if (phy_upd_req == '0) begin
                    state_n = ST_IDLE;
                end else if (sched_idle) begin
                    grant_phy = 1'b1;
                    state_n   = ST_PHY_ACT;
                end
            end
            ST_PHY_ACT: begin
                if (ack_keep == '0)
                    state_n = ST_IDLE;
            end
            ST_CTL_DRAIN: begin
                if (sched_idle) begin
                    state_n   = ST_CTL_WAIT;
                    ctl_req_n = 1'b1;
                    tmr_clear = 1'b1;
                end
            end
            ST_CTL_WAIT: begin
                if (|ctl_upd_ack) begin
                    state_n   = ST_CTL_ACT;
                    ctl_req_n = 1'b0;
                end else if (tmr_expire) begin
                    state_n   = ST_IDLE;
                    ctl_req_n = 1'b0;
                    err_n     = 1'b1;
                end else begin
                    tmr_run = 1'b1;
                end
            end
            ST_CTL_ACT: begin
                if (ctl_upd_ack == '0)
                    state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ctl_req_q <= 1'b0;
            err_q     <= 1'b0;
            hold_q    <= 1'b0;
        end else begin
            state_q   <= state_n;
            ctl_req_q <= ctl_req_n;
            err_q     <= err_n;
            hold_q    <= window_open(state_n);
        end
    end

    assign phy_upd_ack = ack_q;
    assign hold        = hold_q;
    assign ctl_err     = err_q;
endmodule

// File: rtl/upd_coord_chk.sv
module upd_coord_chk #(
    parameter int N_CH = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            sched_idle,
    input logic [N_CH-1:0] phy_upd_req,
    input logic [N_CH-1:0] phy_upd_ack,
    input logic [N_CH-1:0] ctl_upd_req,
    input logic [N_CH-1:0] ctl_upd_ack,
    input logic            hold,
    input logic            ctl_err
);
    assert_ctl_req_uniform_R1: assert property (@(posedge clk) disable iff (rst)
        ($countones(ctl_upd_req) == 0) || ($countones(ctl_upd_req) == N_CH));

    assert_ctl_req_after_drain_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_upd_req[0]) |-> ($past(sched_idle) && $past(hold)));

    assert_hold_covers_R2: assert property (@(posedge clk) disable iff (rst)
        ((|phy_upd_ack) || (|ctl_upd_req)) |-> hold);

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        assert_ack_to_requester_R3: assert property (@(posedge clk) disable iff (rst)
            $rose(phy_upd_ack[ch]) |-> ($past(phy_upd_req[ch]) && $past(sched_idle)));

        assert_ack_release_R5: assert property (@(posedge clk) disable iff (rst)
            (phy_upd_ack[ch] && !phy_upd_req[ch]) |=> !phy_upd_ack[ch]);
    end

    assert_no_late_grant_R4: assert property (@(posedge clk) disable iff (rst)
        (|phy_upd_ack) |=> ((phy_upd_ack & ~$past(phy_upd_ack)) == '0));

    assert_ctl_hold_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (hold && (|ctl_upd_ack)) |=> hold);

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !((|phy_upd_ack) && (|ctl_upd_req)));

    assert_abort_release_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_err) |-> (!hold && $past(ctl_upd_req[0])));
endmodule

bind upd_coord upd_coord_chk #(.N_CH(N_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sched_idle  (sched_idle),
    .phy_upd_req (phy_upd_req),
    .phy_upd_ack (phy_upd_ack),
    .ctl_upd_req (ctl_upd_req),
    .ctl_upd_ack (ctl_upd_ack),
    .hold        (hold),
    .ctl_err     (ctl_err)
);

// File: tb/upd_coord_test.sv
module upd_coord_test;
    localparam int N_CH  = 2;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ctl_want = 1'b0;
    logic             sched_idle = 1'b0;
    logic [CNT_W-1:0] upd_limit = 8'd4;
    logic [N_CH-1:0]  phy_upd_req = '0;
    logic [N_CH-1:0]  phy_upd_ack;
    logic [N_CH-1:0]  ctl_upd_req;
    logic [N_CH-1:0]  ctl_upd_ack = '0;
    logic             hold;
    logic             ctl_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    upd_coord #(.N_CH(N_CH), .CNT_W(CNT_W)) uut (
        .clk         (clk),
        .rst         (rst),
        .ctl_want    (ctl_want),
        .sched_idle  (sched_idle),
        .upd_limit   (upd_limit),
        .phy_upd_req (phy_upd_req),
        .phy_upd_ack (phy_upd_ack),
        .ctl_upd_req (ctl_upd_req),
        .ctl_upd_ack (ctl_upd_ack),
        .hold        (hold),
        .ctl_err     (ctl_err)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        phy_upd_req = 2'b11; ctl_want = 1'b1; sched_idle = 1'b1;
        rst = 1'b1;
        tick(); tick();
        chk("R9 ack in reset", {6'd0, phy_upd_ack}, 8'h0);
        chk("R9 ctl req in reset", {6'd0, ctl_upd_req}, 8'h0);
        chk("R9 hold in reset", {7'd0, hold}, 8'h0);
        chk("R9 err in reset", {7'd0, ctl_err}, 8'h0);
        phy_upd_req = '0; ctl_want = 1'b0; sched_idle = 1'b0;
        rst = 1'b0;
        tick();
    endtask

    task automatic t_phy_single();
        phy_upd_req = 2'b01; sched_idle = 1'b0;
        tick();
        chk("R2 hold rises first", {7'd0, hold}, 8'h1);
        chk("R2 no ack before drain", {6'd0, phy_upd_ack}, 8'h0);
        tick();
        chk("R3 waits for idle", {6'd0, phy_upd_ack}, 8'h0);
        sched_idle = 1'b1;
        tick();
        chk("R3 ack to ch0 only", {6'd0, phy_upd_ack}, 8'h1);
        phy_upd_req = 2'b11;
        tick();
        chk("R4 ch1 locked out", {6'd0, phy_upd_ack}, 8'h1);
        phy_upd_req = 2'b10;
        tick();
        chk("R5 ack drops", {6'd0, phy_upd_ack}, 8'h0);
        chk("R5 hold drops with last ack", {7'd0, hold}, 8'h0);
        tick();
        chk("R2 ch1 opens new window", {7'd0, hold}, 8'h1);
        tick();
        chk("R3 ch1 granted later", {6'd0, phy_upd_ack}, 8'h2);
        phy_upd_req = 2'b00;
        tick();
        chk("R5 ch1 released", {7'd0, hold}, 8'h0);
        sched_idle = 1'b0;
    endtask

    task automatic t_phy_both_uneven();
        phy_upd_req = 2'b11; sched_idle = 1'b0;
        tick();
        phy_upd_req = 2'b01; sched_idle = 1'b1;
        tick();
        chk("R3 snapshot at grant", {6'd0, phy_upd_ack}, 8'h1);
        phy_upd_req = 2'b11;
        tick(); tick();
        chk("R4 still locked", {6'd0, phy_upd_ack}, 8'h1);
        phy_upd_req = 2'b10;
        tick();
        chk("R5 window ends", {7'd0, hold}, 8'h0);
        tick();
        tick();
        chk("R3 both channels", {6'd0, phy_upd_ack}, 8'h2);
        phy_upd_req = 2'b00;
        tick();
        phy_upd_req = 2'b11;
        tick(); tick();
        chk("R3 pair ack", {6'd0, phy_upd_ack}, 8'h3);
        phy_upd_req = 2'b10;
        tick();
        chk("R5 ch0 drops first", {6'd0, phy_upd_ack}, 8'h2);
        chk("R5 hold kept", {7'd0, hold}, 8'h1);
        phy_upd_req = 2'b00;
        tick();
        chk("R5 hold drops", {7'd0, hold}, 8'h0);
        sched_idle = 1'b0;
    endtask

    task automatic t_withdraw();
        phy_upd_req = 2'b10; sched_idle = 1'b0;
        tick();
        chk("R10 hold up", {7'd0, hold}, 8'h1);
        phy_upd_req = 2'b00; sched_idle = 1'b1;
        tick();
        chk("R10 hold falls", {7'd0, hold}, 8'h0);
        chk("R10 no ack", {6'd0, phy_upd_ack}, 8'h0);
        sched_idle = 1'b0;
    endtask

    task automatic t_ctl_priority();
        sched_idle = 1'b1; ctl_want = 1'b1; phy_upd_req = 2'b01;
        tick();
        ctl_want = 1'b0;
        chk("R7 hold up", {7'd0, hold}, 8'h1);
        tick();
        chk("R7 ctl first", {6'd0, ctl_upd_req}, 8'h3);
        chk("R7 no phy ack", {6'd0, phy_upd_ack}, 8'h0);
        ctl_upd_ack = 2'b01;
        tick();
        chk("R6 req drops on first ack", {6'd0, ctl_upd_req}, 8'h0);
        chk("R6 hold kept", {7'd0, hold}, 8'h1);
        ctl_upd_ack = 2'b11;
        tick();
        ctl_upd_ack = 2'b10;
        tick();
        chk("R6 hold over mismatched ack", {7'd0, hold}, 8'h1);
        ctl_upd_ack = 2'b00;
        tick();
        chk("R6 hold released", {7'd0, hold}, 8'h0);
        tick(); tick();
        chk("R7 phy served after", {6'd0, phy_upd_ack}, 8'h1);
        phy_upd_req = 2'b00;
        tick();
        chk("R7 phy done", {7'd0, hold}, 8'h0);
        sched_idle = 1'b0;
    endtask

    task automatic t_ctl_timeout();
        upd_limit = 8'd4; sched_idle = 1'b1; ctl_want = 1'b1;
        tick();
        ctl_want = 1'b0;
        tick();
        chk("R1 req on both", {6'd0, ctl_upd_req}, 8'h3);
        tick(); tick(); tick();
        chk("R8 still waiting", {6'd0, ctl_upd_req}, 8'h3);
        tick();
        chk("R8 req aborted", {6'd0, ctl_upd_req}, 8'h0);
        chk("R8 hold released", {7'd0, hold}, 8'h0);
        chk("R8 err set", {7'd0, ctl_err}, 8'h1);
        ctl_want = 1'b1;
        tick();
        ctl_want = 1'b0;
        chk("R8 err cleared", {7'd0, ctl_err}, 8'h0);
        tick();
        ctl_upd_ack = 2'b11;
        tick();
        ctl_upd_ack = 2'b00;
        tick();
        chk("R8 normal finish", {8'd0, ctl_err}, 8'h0);
        chk("R6 window closed", {7'd0, hold}, 8'h0);
        sched_idle = 1'b0;
    endtask

    task automatic t_ctl_drain_wait();
        sched_idle = 1'b0; ctl_want = 1'b1;
        tick();
        ctl_want = 1'b0;
        tick(); tick();
        chk("R1 req waits for idle", {6'd0, ctl_upd_req}, 8'h0);
        sched_idle = 1'b1;
        tick();
        chk("R1 req after idle", {6'd0, ctl_upd_req}, 8'h3);
        ctl_upd_ack = 2'b10;
        tick();
        ctl_upd_ack = 2'b00;
        tick();
        chk("R6 done", {7'd0, hold}, 8'h0);
        sched_idle = 1'b0;
    endtask

    initial begin
        t_reset();
        t_phy_single();
        t_phy_both_uneven();
        t_withdraw();
        t_ctl_priority();
        t_ctl_timeout();
        t_ctl_drain_wait();
        t_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule